// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that system software must service at regular intervals. It has a small 32-bit register interface with an address, a write strobe, write data and combinational read data. Through it, software sets the operating mode, chooses the count rate and the reload value, restarts the countdown and reads a timeout flag. Each writable register accepts a write only when the written word carries that register's own access key in a fixed field. A restart is accepted only for one exact magic word. Software that runs away is therefore unlikely to reprogram or feed the timer by accident.

The countdown register runs from a prescaled clock. It is loaded with the reload value in its upper bits and all ones in its lower bits. When the count reaches zero, the block sets a sticky timeout flag. It can also drive a reset pulse, an interrupt pulse, or both, and their lengths are programmable in prescaled ticks. After that single expiry the counter stays at zero until software reloads it.

Top module: `keyed_watchdog`

## Requirements
- R1: Registers are decoded at byte offsets 0x0 (mode), 0x4 (count control), 0x8 (restart) and 0xC (status). An address with bits 1:0 not zero selects nothing: a write to it is ignored and a read from it returns zero.
- R2: A write to the mode register takes effect only when bits 23:12 of the write data equal 0xABC. Any other value leaves the mode register unchanged.
- R3: In the mode register, bit 0 enables counting, bit 1 enables the reset pulse, bit 2 enables the interrupt pulse, bits 6:4 hold the reset length code and bits 8:7 hold the interrupt length code. A read returns these fields with every other bit zero.
- R4: A write to the count control register takes effect only when bits 25:14 of the write data equal 0x248. Bits 1:0 hold the rate select and bits 13:2 hold the 12-bit reload value. A read returns these fields with every other bit zero.
- R5: Rate select values 0, 1, 2 and 3 give one prescaled tick every 8, 64, 512 and 4096 clock cycles.
- R6: A write that turns the enable bit from 0 to 1 loads the counter with {reload, LOW_W ones} and restarts the prescaler. While the block is enabled, the counter steps down once per tick. Timeout therefore happens exactly (load value × divider) cycles after the loading edge.
- R7: A write of exactly 0x00001999 to the restart register reloads the counter, restarts the prescaler and clears the timeout flag. Any other value has no effect. The restart register always reads zero.
- R8: Status bit 0 becomes 1 at timeout and stays 1 until a valid restart.
- R9: At timeout, if the reset pulse is enabled, the reset output stays high for 2^(n+1) ticks (n = reset length code) and otherwise stays low.
- R10: At timeout, if the interrupt pulse is enabled, the interrupt output stays high for 4·2^m ticks (m = interrupt length code) and otherwise stays low.
- R11: After timeout the counter stays at zero and produces no further pulses until it is reloaded.
- R12: After reset all registers read zero and both outputs are low.
- R13: A mode write that sets the enable bit while the block is already enabled does not reload the counter.
- R14: While the enable bit is 0 the counter does not advance and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| bite_rst | output | 1 | Timeout reset pulse |
| bite_irq | output | 1 | Timeout interrupt pulse |

## Verification
The assertions check on every cycle that a write with a wrong key leaves the mode and control registers untouched, that the timeout flag holds until a valid restart, that a counter at zero stays there without a reload, that the count moves only on a tick, and that a pulse cannot end between ticks. The exact cycle of expiry for each rate and reload value, the measured pulse widths, the readback masks, and the effect of wrong restart words or of re-enabling during a count can only be shown by the bench's timed scenarios.

// File: rtl/wdt_pkg.sv
// Shared constants and register field types for the key-protected watchdog.
// Assumes a 32-bit register word and the fixed key and field positions below.
package wdt_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned RELOAD_W = 12;
    localparam int unsigned SEL_W    = 2;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_KICK = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam logic [11:0]       MODE_KEY  = 12'hABC;
    localparam logic [11:0]       CTRL_KEY  = 12'h248;
    localparam logic [WORD_W-1:0] KICK_WORD = 32'h0000_1999;

    // Mode fields, packed in the order of their write-data bits 8:4 and 2:0
    typedef struct packed {
        logic [1:0] irq_len;
        logic [2:0] rst_len;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } mode_t;

    // Count control fields, packed in the order of write-data bits 13:0
    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [SEL_W-1:0]    div_sel;
    } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
// Register bank: checks the access keys, holds mode and control, drives read data.
// Assumes single-cycle writes and a word-aligned address; unaligned accesses select nothing.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              timeout_flag,
    output logic [WORD_W-1:0] bus_rdata,
    output mode_t             mode_q,
    output ctrl_t             ctrl_q,
    output logic              kick,
    output logic              arm
);
    logic [1:0] sel;
    logic       aligned;
    logic       mode_ok;
    logic       ctrl_ok;

    assign sel     = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign mode_ok = bus_we && aligned && (sel == SEL_MODE) && (bus_wdata[23:12] == MODE_KEY);
    assign ctrl_ok = bus_we && aligned && (sel == SEL_CTRL) && (bus_wdata[25:14] == CTRL_KEY);
    assign kick    = bus_we && aligned && (sel == SEL_KICK) && (bus_wdata == KICK_WORD);
    assign arm     = mode_ok && bus_wdata[0] && !mode_q.run;

    // Mode register, updated only by a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_ok) mode_q <= mode_t'({bus_wdata[8:4], bus_wdata[2:0]});
    end

    // Count control register, updated only by a keyed write
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_ok) ctrl_q <= ctrl_t'(bus_wdata[13:0]);
    end

    // Read multiplexer; key fields and the restart register read as zero
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_MODE: bus_rdata[8:0] = {mode_q.irq_len, mode_q.rst_len, 1'b0,
                                            mode_q.irq_en, mode_q.rst_en, mode_q.run};
                SEL_CTRL: bus_rdata[13:0] = ctrl_q;
                SEL_STAT: bus_rdata[0] = timeout_flag;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2
    mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_MODE && bus_wdata[23:12] != MODE_KEY) |=> $stable(mode_q));

    // R4
    ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_CTRL && bus_wdata[25:14] != CTRL_KEY) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_prescaler.sv
// Prescaler: emits a one-cycle tick every 2^(BASE_LOG2 + STEP_LOG2*div_sel) clocks.
// Assumes clear has priority and the count restarts from zero whenever run is low.
module wdt_prescaler #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned BASE_LOG2 = 3,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int unsigned NUM_DIV = 2 ** SEL_W;
    localparam int unsigned PRE_W   = BASE_LOG2 + STEP_LOG2 * (NUM_DIV - 1);

    logic [PRE_W-1:0] limits [NUM_DIV];
    logic [PRE_W-1:0] pre_q;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_limit
        assign limits[g] = PRE_W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * g)) - 64'd1);
    end

    assign tick = run && !clear && (pre_q >= limits[div_sel]);

    // Cycle counter between ticks
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) pre_q <= '0;
        else if (tick)               pre_q <= '0;
        else                         pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdt_pulse.sv
// Pulse stretcher: on start, holds active for 2^(BASE_LOG2 + code) ticks.
// Assumes start coincides with a tick and has priority over the down-count.
module wdt_pulse #(
    parameter int unsigned CODE_W    = 3,
    parameter int unsigned BASE_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              active
);
    localparam int unsigned LEN_W = BASE_LOG2 + (2 ** CODE_W - 1) + 1;

    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] left_q;

    assign len    = LEN_W'(1) << (BASE_LOG2 + int'(code));
    assign active = (left_q != '0);

    // Remaining pulse length in ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                     left_q <= '0;
        else if (start)                 left_q <= len;
        else if (tick && left_q != '0)  left_q <= left_q - 1'b1;
    end

    // R9 R10
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !start) |=> active);
endmodule

// File: rtl/keyed_watchdog.sv
// Key-protected watchdog top: register bank, prescaler, countdown and two output pulses.
// Assumes one synchronous clock; the counter reloads with {reload, LOW_W ones}.
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned LOW_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bite_rst,
    output logic              bite_irq
);
    localparam int unsigned CNT_W = RELOAD_W + LOW_W;

    mode_t            mode_q;
    ctrl_t            ctrl_q;
    logic             kick;
    logic             arm;
    logic             load;
    logic             tick;
    logic             expire;
    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;

    wdt_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .timeout_flag (flag_q),
        .bus_rdata    (bus_rdata),
        .mode_q       (mode_q),
        .ctrl_q       (ctrl_q),
        .kick         (kick),
        .arm          (arm)
    );

    assign load = arm || kick;

    wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(3), .STEP_LOG2(3)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mode_q.run || bite_rst || bite_irq),
        .clear   (load),
        .div_sel (ctrl_q.div_sel),
        .tick    (tick)
    );

    assign expire = mode_q.run && tick && !load && (cnt_q == CNT_W'(1));

    // Countdown: reload on arm or restart, step down per tick while enabled
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (load)                             cnt_q <= {ctrl_q.reload, {LOW_W{1'b1}}};
        else if (mode_q.run && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Sticky timeout flag, cleared only by a valid restart
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (kick)   flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;
    end

    wdt_pulse #(.CODE_W(3), .BASE_LOG2(1)) u_rst_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (expire && mode_q.rst_en),
        .tick   (tick),
        .code   (mode_q.rst_len),
        .active (bite_rst)
    );

    wdt_pulse #(.CODE_W(2), .BASE_LOG2(2)) u_irq_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (expire && mode_q.irq_en),
        .tick   (tick),
        .code   (mode_q.irq_len),
        .active (bite_irq)
    );

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !kick) |=> flag_q);

    // R11
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> (cnt_q == '0));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_W      = 4;
    localparam int WD_CYCLES  = 195000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bite_rst;
    logic        bite_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyed_watchdog #(.LOW_W(LOW_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bite_rst  (bite_rst),
        .bite_irq  (bite_irq)
    );

    function automatic logic [31:0] mk_mode(input bit run, input bit re, input bit ie,
                                            input logic [2:0] rl, input logic [1:0] il);
        return {8'h00, 12'hABC, 3'b000, il, rl, 1'b0, ie, re, run};
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [11:0] reload, input logic [1:0] psel);
        return {6'h00, 12'h248, reload, psel};
    endfunction

    function automatic int div_of(input int psel);
        return 8 << (3 * psel);
    endfunction

    function automatic int timeout_cycles(input int reload, input int psel);
        return ((reload << LOW_W) | ((1 << LOW_W) - 1)) * div_of(psel);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40000; i++) begin
            if (!bite_rst && !bite_irq) break;
            @(negedge clk);
        end
    endtask

    // Disable, program, restart, then enable: returns just after the arming edge
    task automatic arm_cfg(input int reload, input int psel, input bit re, input bit ie,
                           input int rl, input int il);
        wait_idle();
        bus_wr(4'h0, mk_mode(0, re, ie, 3'(rl), 2'(il)));
        bus_wr(4'h4, mk_ctrl(12'(reload), 2'(psel)));
        bus_wr(4'h8, 32'h0000_1999);
        bus_wr(4'h0, mk_mode(1, re, ie, 3'(rl), 2'(il)));
    endtask

    task automatic expect_timeout(input string tag, input int t, input int elapsed,
                                  input int rst_w, input int irq_w);
        logic [31:0] d;
        int rh, ih;
        repeat (t - 1 - elapsed) @(negedge clk);
        rd(4'hC, d);
        check({tag, " R6 no timeout one cycle early"}, d, 32'd0);
        @(negedge clk);
        rd(4'hC, d);
        check({tag, " R8 status set at timeout"}, d, 32'd1);
        rh = 0; ih = 0;
        for (int i = 0; i < 40000; i++) begin
            if (bite_rst) rh++;
            if (bite_irq) ih++;
            if (!bite_rst && !bite_irq) break;
            @(negedge clk);
        end
        check({tag, " R9 reset pulse width"}, rh, rst_w);
        check({tag, " R10 interrupt pulse width"}, ih, irq_w);
        repeat (40) @(negedge clk);
        check({tag, " R11 no pulse after expiry"}, {30'd0, bite_rst, bite_irq}, 32'd0);
        rd(4'hC, d);
        check({tag, " R8 status still set"}, d, 32'd1);
    endtask

    task automatic scenario(input string tag, input int reload, input int psel,
                            input bit re, input bit ie, input int rl, input int il);
        arm_cfg(reload, psel, re, ie, rl, il);
        expect_timeout(tag, timeout_cycles(reload, psel), 0,
                       re ? (2 << rl) * div_of(psel) : 0,
                       ie ? (4 << il) * div_of(psel) : 0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, mode_m, ctrl_m, w;
        int t;
        void'($urandom(32'd20240611));
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a * 4), d);
            check("R12 register reads zero after reset", d, 32'd0);
        end
        check("R12 outputs low after reset", {30'd0, bite_rst, bite_irq}, 32'd0);

        // R2 wrong mode key
        bus_wr(4'h0, mk_mode(1, 1, 1, 3'd5, 2'd2) ^ 32'h0000_1000);
        rd(4'h0, d);
        check("R2 mode write with wrong key ignored", d, 32'd0);

        // R3 readback mask
        bus_wr(4'h0, 32'hFFAB_CFF6);
        rd(4'h0, d);
        check("R3 mode readback fields only", d, 32'h0000_01F6);
        mode_m = 32'h0000_01F6;

        // R4 keyed and wrong-key control writes
        bus_wr(4'h4, 32'hFC92_3FFF);
        rd(4'h4, d);
        check("R4 control readback fields only", d, 32'h0000_3FFF);
        bus_wr(4'h4, 32'h0000_0123);
        rd(4'h4, d);
        check("R4 control write with wrong key ignored", d, 32'h0000_3FFF);
        ctrl_m = 32'h0000_3FFF;

        // R1 unaligned access selects nothing
        bus_wr(4'h5, mk_ctrl(12'h005, 2'd1));
        rd(4'h4, d);
        check("R1 unaligned write ignored", d, ctrl_m);
        rd(4'h5, d);
        check("R1 unaligned read zero", d, 32'd0);

        // R7 restart reads zero
        bus_wr(4'h8, 32'h0000_1999);
        rd(4'h8, d);
        check("R7 restart register reads zero", d, 32'd0);

        // Random keyed and unkeyed writes against the bench model (R2 R3 R4)
        for (int i = 0; i < 40; i++) begin
            bit to_ctrl, good;
            to_ctrl = 1'($urandom_range(0, 1));
            good    = 1'($urandom_range(0, 1));
            w = $urandom();
            w[0] = 1'b0;
            if (!to_ctrl) begin
                w[23:12] = good ? 12'hABC : (12'hABC ^ 12'($urandom_range(1, 4095)));
                bus_wr(4'h0, w);
                if (good) mode_m = w & 32'h0000_01F6;
                rd(4'h0, d);
                check("R2 R3 random mode write readback", d, mode_m);
            end else begin
                w[25:14] = good ? 12'h248 : (12'h248 ^ 12'($urandom_range(1, 4095)));
                bus_wr(4'h4, w);
                if (good) ctrl_m = w & 32'h0000_3FFF;
                rd(4'h4, d);
                check("R4 random control write readback", d, ctrl_m);
            end
        end

        // R5 R6 R9 R10 directed rates and lengths
        scenario("rate0 both pulses", 0, 0, 1, 1, 0, 0);
        bus_wr(4'h8, 32'h0000_1999);
        rd(4'hC, d);
        check("R7 valid restart clears status", d, 32'd0);
        scenario("rate1 long irq", 1, 1, 0, 1, 0, 3);
        scenario("rate2 reset only", 0, 2, 1, 0, 2, 0);
        scenario("rate3 reset only", 0, 3, 1, 0, 0, 0);
        scenario("rate0 longest reset", 2, 0, 1, 0, 7, 0);
        scenario("rate0 no pulses", 3, 0, 0, 0, 4, 1);

        // R7 wrong restart word has no effect
        t = timeout_cycles(1, 0);
        arm_cfg(1, 0, 1, 0, 1, 0);
        repeat (20) @(negedge clk);
        bus_wr(4'h8, 32'h0000_1998);
        expect_timeout("R7 wrong restart", t, 22, 4 * 8, 0);

        // R7 valid restart mid-count restarts the full interval
        arm_cfg(1, 0, 1, 1, 0, 1);
        repeat (100) @(negedge clk);
        bus_wr(4'h8, 32'h0000_1999);
        expect_timeout("R7 restart mid count", t, 0, 2 * 8, 8 * 8);

        // R13 re-enable while running does not reload
        arm_cfg(1, 0, 1, 0, 0, 0);
        repeat (30) @(negedge clk);
        bus_wr(4'h0, mk_mode(1, 1, 0, 3'd0, 2'd0));
        expect_timeout("R13 re-enable", t, 32, 2 * 8, 0);

        // R14 disabled counter does not expire; re-enable rearms
        arm_cfg(0, 0, 1, 0, 0, 0);
        repeat (50) @(negedge clk);
        bus_wr(4'h0, mk_mode(0, 1, 0, 3'd0, 2'd0));
        repeat (300) @(negedge clk);
        rd(4'hC, d);
        check("R14 no timeout while disabled", d, 32'd0);
        check("R14 no pulse while disabled", {30'd0, bite_rst, bite_irq}, 32'd0);
        bus_wr(4'h0, mk_mode(1, 1, 0, 3'd0, 2'd0));
        expect_timeout("R14 re-armed", timeout_cycles(0, 0), 0, 2 * 8, 0);

        // Random timeout scenarios
        for (int i = 0; i < 8; i++) begin
            int psel, rl;
            psel = $urandom_range(0, 1);
            rl   = (psel == 0) ? $urandom_range(0, 7) : $urandom_range(0, 2);
            scenario("random timeout", $urandom_range(0, 3), psel,
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     rl, $urandom_range(0, 3));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule